// File: doc/BRIEF.md
# Carry-Flag Arithmetic Logic Unit

This block is the arithmetic and logic stage of a small microcontroller-style core. Each cycle it takes an operation code, a first operand and a second operand. The second operand is either a second register value or a zero-extended 8-bit immediate, chosen by an immediate-select bit. The result is combinational and appears on the output in the same cycle as the inputs.

A single carry flag is held in a flop. The six add and subtract forms rewrite it on the clock edge that follows an operation presented with the valid strobe high. Every other operation leaves the flag alone. After any subtract form the flag holds the inverted borrow, so a 1 means the subtraction did not borrow. The borrowing subtract forms take the inverse of the stored flag as their borrow input.

The operation set also covers shifts, bitwise logic, unsigned minimum and maximum, single-bit clear and set, and a search from the top bit down for the first bit equal to a chosen value. Register file, decode and memory access are handled by neighbouring blocks.

Top module: `carry_alu`

## Requirements
- R1: When `imm_sel_i` is 1, the second operand is `imm_i` zero-extended to 32 bits. When `imm_sel_i` is 0, the second operand is `rs2_i`.
- R2: Opcode 0 (add) gives a+b. Opcode 1 (add with carry) gives a+b+flag. For both, the new flag is bit 32 of the 33-bit sum.
- R3: Opcode 2 (subtract) gives a−b. The new flag is 1 when a ≥ b unsigned, so it is the inverse of the borrow.
- R4: Opcode 3 gives a−b−(not flag). Opcode 4 gives b−a. Opcode 5 gives b−a−(not flag). For each, the new flag is the inverse of the borrow out of the 32-bit difference.
- R5: Opcode 6 shifts a left and opcode 7 shifts a right (logical). The shift amount is the low 5 bits of b.
- R6: Opcodes 8, 9 and 10 give a AND b, a OR b and a XOR b. Opcode 11 gives NOT a, and b has no effect on it.
- R7: Opcode 12 gives the unsigned minimum of a and b. Opcode 13 gives the unsigned maximum.
- R8: Opcode 14 gives a with bit b[4:0] forced to 0. Opcode 15 gives a with that bit forced to 1.
- R9: Opcode 16 scans a from bit 31 down to bit 0 and returns the index of the first bit equal to b[0]. It returns 32 when no bit matches.
- R10: The flag is written only on a clock edge where `valid_i` is 1 and the opcode is 0 to 5. Any other opcode, or `valid_i` low, leaves it unchanged.
- R11: An active-low reset clears the flag to 0.
- R12: Opcodes 17 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe that allows the carry flag to be written |
| op_i | input | 5 | Operation code |
| imm_sel_i | input | 1 | Selects the immediate as the second operand |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Second register operand |
| imm_i | input | 8 | Immediate operand, zero-extended |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Registered carry flag |

## Verification
The carry flag is the only state in the block. A wrong flag shows at the ports in two ways. First, `carry_o` holds the wrong value from the next clock edge onward. Second, the next add with carry or borrowing subtract produces a result that is off by one in that same cycle. A write that should not happen, or a missing write, is caught at the first sample after the edge, because the bench tracks its own copy of the flag and compares it before every operation. Long runs of flag-neutral operations between arithmetic ones test that the flag holds across many cycles.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBC  = 5'd3,
      OP_RSUB  = 5'd4,
      OP_RSUBC = 5'd5,
      OP_SHL   = 5'd6,
      OP_SHR   = 5'd7,
      OP_AND   = 5'd8,
      OP_OR    = 5'd9,
      OP_XOR   = 5'd10,
      OP_NOT   = 5'd11,
      OP_MIN   = 5'd12,
      OP_MAX   = 5'd13,
      OP_BCLR  = 5'd14,
      OP_BSET  = 5'd15,
      OP_LMBD  = 5'd16
   } alu_op_e;

   // True for the operations that rewrite the carry flag (opcodes 0 to 5).
   function automatic logic op_writes_carry(input logic [4:0] op);
      return (op <= 5'd5);
   endfunction

   function automatic logic op_is_arith(input logic [4:0] op);
      return (op <= 5'd5);
   endfunction

   function automatic logic op_is_logic(input logic [4:0] op);
      return (op >= 5'd6) && (op <= 5'd15);
   endfunction

endpackage

// File: rtl/carry_alu_addsub.sv
module carry_alu_addsub
   import carry_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [4:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   logic             swap, is_sub, use_flag, c0;
   logic [WIDTH-1:0] x, y, y_eff;
   logic [WIDTH:0]   wide;

   always_comb begin
      swap     = (op == OP_RSUB) || (op == OP_RSUBC);
      is_sub   = (op == OP_SUB) || (op == OP_SUBC) || swap;
      use_flag = (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_RSUBC);
      x        = swap ? b : a;
      y        = swap ? a : b;
      // x - y - !c is the same as x + ~y + c. Its carry out is the inverse of the borrow.
      y_eff    = is_sub ? ~y : y;
      c0       = use_flag ? cin : is_sub;
      wide     = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, c0};
      res      = wide[WIDTH-1:0];
      cout     = wide[WIDTH];
   end

endmodule

// File: rtl/carry_alu_bitops.sv
module carry_alu_bitops
   import carry_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [4:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] res
);

   localparam int SH_W = $clog2(WIDTH);

   logic [SH_W-1:0]  idx;
   logic [WIDTH-1:0] one_hot;

   always_comb begin
      idx     = b[SH_W-1:0];
      one_hot = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
      unique case (op)
         OP_SHL:  res = a << idx;
         OP_SHR:  res = a >> idx;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_MIN:  res = (a < b) ? a : b;
         OP_MAX:  res = (a > b) ? a : b;
         OP_BCLR: res = a & ~one_hot;
         OP_BSET: res = a | one_hot;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/carry_alu_bitscan.sv
module carry_alu_bitscan #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]        a,
   input  logic                    want,
   output logic [$clog2(WIDTH):0]  pos
);

   localparam int POS_W = $clog2(WIDTH) + 1;

   logic [WIDTH-1:0] hit;

   for (genvar g = 0; g < WIDTH; g++) begin : g_hit
      assign hit[g] = ~(a[g] ^ want);
   end

   always_comb begin
      logic found;
      found = 1'b0;
      pos   = POS_W'(WIDTH);
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (!found && hit[i]) begin
            pos   = POS_W'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/carry_alu_flag.sv
module carry_alu_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (we) q <= d;
   end

endmodule

// File: rtl/carry_alu.sv
module carry_alu
   import carry_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [4:0]       op_i,
   input  logic             imm_sel_i,
   input  logic [31:0]      rs1_i,
   input  logic [31:0]      rs2_i,
   input  logic [7:0]       imm_i,
   output logic [31:0]      result_o,
   output logic             carry_o
);

   localparam int POS_W = $clog2(WIDTH) + 1;

   if (WIDTH != 32 || IMM_W != 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_cfg
      $error("carry_alu: WIDTH must be 32 and IMM_W must be 8 to match the ports");
   end

   logic [WIDTH-1:0] opb, arith_res, bit_res;
   logic             arith_cout;
   logic [POS_W-1:0] scan_pos;

   assign opb = imm_sel_i ? {{(WIDTH-IMM_W){1'b0}}, imm_i} : rs2_i;

   carry_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .op   (op_i),
      .a    (rs1_i),
      .b    (opb),
      .cin  (carry_o),
      .res  (arith_res),
      .cout (arith_cout)
   );

   carry_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
      .op  (op_i),
      .a   (rs1_i),
      .b   (opb),
      .res (bit_res)
   );

   carry_alu_bitscan #(.WIDTH(WIDTH)) u_scan (
      .a    (rs1_i),
      .want (opb[0]),
      .pos  (scan_pos)
   );

   carry_alu_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (valid_i && op_writes_carry(op_i)),
      .d     (arith_cout),
      .q     (carry_o)
   );

   always_comb begin
      if (op_is_arith(op_i))       result_o = arith_res;
      else if (op_is_logic(op_i))  result_o = bit_res;
      else if (op_i == OP_LMBD)    result_o = {{(WIDTH-POS_W){1'b0}}, scan_pos};
      else                         result_o = '0;
   end

endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        valid_i,
   input logic [4:0]  op_i,
   input logic        imm_sel_i,
   input logic [31:0] rs1_i,
   input logic [31:0] rs2_i,
   input logic [7:0]  imm_i,
   input logic [31:0] result_o,
   input logic        carry_o
);

   logic [31:0] b_chk;
   logic [32:0] sum_chk;

   assign b_chk   = imm_sel_i ? {24'd0, imm_i} : rs2_i;
   assign sum_chk = {1'b0, rs1_i} + {1'b0, b_chk};

   p_reset_clear_r11: assert property (@(posedge clk) !rst_n |=> !carry_o);

   p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && op_i <= 5'd5) |=> $stable(carry_o));

   p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 5'd0) |=> carry_o == $past(sum_chk[32]));

   p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 5'd2) |=> carry_o == $past(rs1_i >= b_chk));

   p_not_ignores_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd11) |-> result_o == ~rs1_i);

   p_min_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd12) |-> (result_o <= rs1_i && result_o <= b_chk));

   p_set_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd15) |-> result_o[b_chk[4:0]]);

   p_scan_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd16) |-> result_o <= 32'd32);

   p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 5'd16) |-> result_o == 32'd0);

endmodule

bind carry_alu carry_alu_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/carry_alu_test.sv
module carry_alu_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_i;
   logic [4:0]  op_i;
   logic        imm_sel_i;
   logic [31:0] rs1_i, rs2_i;
   logic [7:0]  imm_i;
   logic [31:0] result_o;
   logic        carry_o;

   int checks = 0;
   int fails  = 0;
   logic flag_model = 1'b0;
   string flag_tag = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   carry_alu uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .imm_sel_i(imm_sel_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
      .result_o(result_o), .carry_o(carry_o)
   );

   function automatic string req_of(input logic [4:0] op);
      if (op <= 1)       return "R2";
      else if (op == 2)  return "R3";
      else if (op <= 5)  return "R4";
      else if (op <= 7)  return "R5";
      else if (op <= 11) return "R6";
      else if (op <= 13) return "R7";
      else if (op <= 15) return "R8";
      else if (op == 16) return "R9";
      return "R12";
   endfunction

   // Returns {new_flag, result}. The new flag is only meaningful for opcodes 0 to 5.
   function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic c);
      logic [32:0] t;
      logic [31:0] r;
      int k;
      t = '0;
      r = '0;
      case (op)
         0: t = {1'b0, a} + {1'b0, b};
         1: t = {1'b0, a} + {1'b0, b} + {32'd0, c};
         2: begin t = {1'b0, a} - {1'b0, b};            t[32] = ~t[32]; end
         3: begin t = {1'b0, a} - {1'b0, b} - {32'd0, ~c}; t[32] = ~t[32]; end
         4: begin t = {1'b0, b} - {1'b0, a};            t[32] = ~t[32]; end
         5: begin t = {1'b0, b} - {1'b0, a} - {32'd0, ~c}; t[32] = ~t[32]; end
         6: r = a << b[4:0];
         7: r = a >> b[4:0];
         8: r = a & b;
         9: r = a | b;
         10: r = a ^ b;
         11: r = ~a;
         12: r = (a < b) ? a : b;
         13: r = (a > b) ? a : b;
         14: begin r = a; r[b[4:0]] = 1'b0; end
         15: begin r = a; r[b[4:0]] = 1'b1; end
         16: begin
            r = 32'd32;
            for (k = 0; k < 32; k++) if (a[k] == b[0]) r = k;
         end
         default: r = '0;
      endcase
      if (op <= 5) return t;
      return {1'b0, r};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [4:0] op, input logic sel, input logic [31:0] a,
                         input logic [31:0] r2, input logic [7:0] im, input logic v,
                         input string note);
      logic [31:0] b;
      logic [32:0] e;
      @(negedge clk);
      op_i = op; imm_sel_i = sel; rs1_i = a; rs2_i = r2; imm_i = im; valid_i = v;
      #1;
      b = sel ? {24'd0, im} : r2;
      e = model(op, a, b, flag_model);
      check({note, req_of(op)}, result_o, e[31:0]);
      check({flag_tag, " flag"}, {31'd0, carry_o}, {31'd0, flag_model});
      if (v && op <= 5) begin
         flag_model = e[32];
         flag_tag   = req_of(op);
      end else begin
         flag_tag = "R10";
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] wa, wb;
      rst_n = 1'b0; valid_i = 1'b0; op_i = '0; imm_sel_i = 1'b0;
      rs1_i = '0; rs2_i = '0; imm_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset", {31'd0, carry_o}, 32'd0);
      rst_n = 1'b1;

      // Directed corners
      run_op(0, 0, 32'hFFFF_FFFF, 32'd1, 8'h00, 1, "");          // wraps, flag 1
      run_op(1, 0, 32'd10, 32'd20, 8'h00, 1, "");                // uses flag 1
      run_op(2, 0, 32'd5, 32'd5, 8'h00, 1, "");                  // no borrow
      run_op(2, 0, 32'd3, 32'd5, 8'h00, 1, "");                  // borrow, flag 0
      run_op(3, 0, 32'd9, 32'd4, 8'h00, 1, "");                  // extra -1
      run_op(4, 0, 32'd4, 32'd9, 8'h00, 1, "");
      run_op(5, 0, 32'd9, 32'd4, 8'h00, 1, "");
      run_op(2, 0, 32'd1, 32'd2, 8'h00, 0, "R10 ");              // no strobe, flag held
      run_op(8, 0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 8'h00, 1, "R10 ");
      run_op(0, 1, 32'd1, 32'hFFFF_FFFF, 8'hFF, 1, "R1 ");       // immediate, not rs2
      run_op(9, 1, 32'h1234_0000, 32'h0000_FFFF, 8'h5A, 1, "R1 ");
      run_op(6, 0, 32'h0000_0003, 32'd33, 8'h00, 1, "");         // shift by 1
      run_op(7, 1, 32'h8000_0000, 32'd0, 8'h3F, 1, "");          // shift by 31
      run_op(11, 0, 32'h0F0F_0000, 32'hFFFF_FFFF, 8'h00, 1, "");
      run_op(12, 0, 32'h8000_0000, 32'd1, 8'h00, 1, "");
      run_op(13, 0, 32'h8000_0000, 32'd1, 8'h00, 1, "");
      run_op(14, 0, 32'hFFFF_FFFF, 32'd63, 8'h00, 1, "");
      run_op(15, 1, 32'h0, 32'd0, 8'h20, 1, "");
      run_op(16, 0, 32'hFFFF_FFFF, 32'd0, 8'h00, 1, "");         // none match
      run_op(16, 1, 32'h0000_0010, 32'd0, 8'h01, 1, "");
      run_op(16, 0, 32'hFFFF_FFFF, 32'd1, 8'h00, 1, "");         // bit 31
      run_op(31, 0, 32'h1234_5678, 32'd7, 8'h00, 1, "");
      run_op(17, 1, 32'hFFFF_FFFF, 32'd7, 8'hFF, 1, "");

      // Random mix with a fixed seed
      void'($urandom(32'd24680));
      for (int i = 0; i < 4000; i++) begin
         logic [4:0] rop;
         rop = 5'($urandom % 20);
         wa = $urandom;
         wb = $urandom;
         if (($urandom % 8) == 0) wa = 32'hFFFF_FFFF;
         if (($urandom % 8) == 0) wb = wa;
         run_op(rop, 1'($urandom), wa, wb, 8'($urandom), ($urandom % 4) != 0, "");
      end

      @(negedge clk);
      check({flag_tag, " final flag"}, {31'd0, carry_o}, {31'd0, flag_model});
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule